// File: doc/BRIEF.md
# Multi-Frame Byte FIFO with Frame and Byte Counters

This block queues whole frames of bytes between a producer and a consumer. The bytes sit in a 512-entry ring that two 9-bit byte pointers walk: a write pointer and a read pointer. Frame boundaries are kept apart from the bytes, in a 16-slot ring of frame pointers and a 16-entry table. Each slot of the table holds the byte position where a closed frame ends. Because of this table, the producer can queue several frames while the consumer drains them one at a time, and both sides still see exact counts.

The producer presents one byte per cycle with `wr_en` and raises `wr_last` on the final byte of a frame. A frame longer than the configured limit is dropped whole when it closes. The consumer reads the bytes of the oldest complete frame with `rd_en`. It retires that frame with `rd_done`, which also skips any bytes left unread. Two packed status words report the counts. The producer-side word gives free bytes and free frame slots. The consumer-side word gives the bytes left in the oldest frame and the number of complete frames. One-cycle flags mark three events: an ignored write, an ignored read and a rejected frame.

Top module: `hfifo_top`

## Requirements
- R1: After reset, `tx_stat` reads 15 free slots and 511 free bytes, `rx_stat` reads 0, `rd_data` is 0 and `ovf`, `unf` and `rej` are low.
- R2: The free-byte field of `tx_stat` equals 511 minus the bytes held, modulo 512. Bytes of a frame still open count as held. The field updates in the cycle after the clock edge that accepts a write or a read.
- R3: A write with `wr_last` closes the frame. Free slots (`tx_stat[19:16]`) then equal 15 minus the closed frames still queued, and the frame count changes only on a frame close or a retire.
- R4: `rx_stat[15:0]` holds the bytes not yet read from the oldest complete frame, or 0 when no frame is complete. `rx_stat[19:16]` holds the number of complete frames.
- R5: In both status words, bits 19:16 carry the frame field and bits 15:0 carry the byte field, zero-extended.
- R6: Bytes come out in write order. `rd_data` carries the byte in the cycle after the edge that samples `rd_en`, and it holds its value when no read takes place.
- R7: `rd_done` retires the oldest complete frame. Any bytes of that frame left unread are discarded, and the read position moves to the start of the next frame.
- R8: A frame whose length on closing exceeds 510 bytes is dropped. Its bytes are released, no frame is queued, and `rej` pulses for one cycle.
- R9: A write while free bytes or free slots are 0 is ignored. `ovf` pulses for one cycle and the counts do not change.
- R10: A read when `rx_stat[15:0]` is 0, or a retire when no frame is complete, is ignored. `unf` pulses for one cycle, an ignored read returns 0 on `rd_data`, and the counts do not change.
- R11: Byte and frame pointers wrap modulo 512 and modulo 16. Data and counts stay correct across many wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one byte |
| wr_last | input | 1 | Written byte closes the frame |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read one byte of the oldest complete frame |
| rd_done | input | 1 | Retire the oldest complete frame |
| rd_data | output | 8 | Byte read, registered |
| tx_stat | output | 20 | Free slots [19:16], free bytes [15:0] |
| rx_stat | output | 20 | Complete frames [19:16], bytes left in oldest frame [15:0] |
| ovf | output | 1 | Write ignored (pulse) |
| unf | output | 1 | Read or retire ignored (pulse) |
| rej | output | 1 | Oversized frame dropped (pulse) |

## Verification
Every result is due exactly one cycle after the clock edge that samples its stimulus. The pointers, the read data register and the three event flags are registered. Both status words are decoded from those registers without further delay. The bench drives a whole cycle of inputs just after an edge, waits for the next rising edge, and then samples 1 ns later, well clear of either edge. As a result, each check reads the first value produced by that stimulus and never a value from the cycle before or the cycle after.

// File: rtl/hfifo_pkg.sv
package hfifo_pkg;

    // lowest bit of the frame field inside a packed status word
    localparam int STAT_LO = 16;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic rej;
    } flags_t;

endpackage

// File: rtl/hfifo_ram.sv
module hfifo_ram #(
    parameter int DW = 8,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/hfifo_ztab.sv
module hfifo_ztab #(
    parameter int ZW = 9,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [FW-1:0] waddr,
    input  logic [ZW-1:0] wdata,
    input  logic [FW-1:0] raddr,
    output logic [ZW-1:0] rdata
);
    localparam int SLOTS = 1 << FW;

    logic [ZW-1:0] ends_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                ends_q[i] <= '0;
            end
        end else if (we) begin
            ends_q[waddr] <= wdata;
        end
    end

    assign rdata = ends_q[raddr];

endmodule

// File: rtl/hfifo_count.sv
module hfifo_count #(
    parameter int ZW = 9,
    parameter int FW = 4
) (
    input  logic [ZW-1:0] z1,
    input  logic [ZW-1:0] z2,
    input  logic [FW-1:0] f1,
    input  logic [FW-1:0] f2,
    input  logic [ZW-1:0] zend,
    output logic [ZW-1:0] free_bytes,
    output logic [FW-1:0] free_frames,
    output logic [FW-1:0] rx_frames,
    output logic [ZW-1:0] rx_bytes
);
    localparam logic [ZW-1:0] ZTOP = '1;
    localparam logic [FW-1:0] FTOP = '1;

    logic [ZW-1:0] used;

    always_comb begin
        used        = z1 - z2;
        free_bytes  = ZTOP - used;
        rx_frames   = f1 - f2;
        free_frames = FTOP - rx_frames;
        rx_bytes    = (rx_frames == '0) ? '0 : (zend - z2);
    end

endmodule

// File: rtl/hfifo_top.sv
module hfifo_top
    import hfifo_pkg::*;
#(
    parameter int DW        = 8,
    parameter int ZW        = 9,
    parameter int FW        = 4,
    parameter int MAX_FRAME = 510
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_last,
    input  logic [DW-1:0]         wr_data,
    input  logic                  rd_en,
    input  logic                  rd_done,
    output logic [DW-1:0]         rd_data,
    output logic [STAT_LO+FW-1:0] tx_stat,
    output logic [STAT_LO+FW-1:0] rx_stat,
    output logic                  ovf,
    output logic                  unf,
    output logic                  rej
);
    localparam logic [ZW-1:0] FRAME_LIM = ZW'(MAX_FRAME);

    typedef struct packed {
        logic [ZW-1:0] z1;   // write position
        logic [ZW-1:0] z2;   // read position
        logic [ZW-1:0] zs;   // start of the open frame
        logic [FW-1:0] f1;   // frame write slot
        logic [FW-1:0] f2;   // frame read slot
        logic [DW-1:0] rdat;
        flags_t        fl;
    } state_t;

    state_t st_d, st_q;

    logic          mem_we;
    logic [DW-1:0] mem_rdata;
    logic          tab_we;
    logic [ZW-1:0] tab_wdata;
    logic [ZW-1:0] zend;
    logic [ZW-1:0] free_bytes;
    logic [FW-1:0] free_frames;
    logic [FW-1:0] rx_frames;
    logic [ZW-1:0] rx_bytes;
    logic [ZW-1:0] z1_inc;
    logic [ZW-1:0] flen;
    logic          wr_ok;

    hfifo_ram #(.DW(DW), .AW(ZW)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (st_q.z1),
        .wdata (wr_data),
        .raddr (st_q.z2),
        .rdata (mem_rdata)
    );

    hfifo_ztab #(.ZW(ZW), .FW(FW)) u_ztab (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tab_we),
        .waddr (st_q.f1),
        .wdata (tab_wdata),
        .raddr (st_q.f2),
        .rdata (zend)
    );

    hfifo_count #(.ZW(ZW), .FW(FW)) u_count (
        .z1          (st_q.z1),
        .z2          (st_q.z2),
        .f1          (st_q.f1),
        .f2          (st_q.f2),
        .zend        (zend),
        .free_bytes  (free_bytes),
        .free_frames (free_frames),
        .rx_frames   (rx_frames),
        .rx_bytes    (rx_bytes)
    );

    always_comb begin
        st_d      = st_q;
        st_d.fl   = '0;
        mem_we    = 1'b0;
        tab_we    = 1'b0;
        z1_inc    = st_q.z1 + 1'b1;
        tab_wdata = z1_inc;
        flen      = z1_inc - st_q.zs;
        wr_ok     = wr_en && (free_bytes != '0) && (free_frames != '0);

        // producer side
        if (wr_en && !wr_ok) begin
            st_d.fl.ovf = 1'b1;
        end
        if (wr_ok) begin
            mem_we  = 1'b1;
            st_d.z1 = z1_inc;
            if (wr_last) begin
                if (flen > FRAME_LIM) begin
                    st_d.z1     = st_q.zs;
                    st_d.fl.rej = 1'b1;
                end else begin
                    tab_we  = 1'b1;
                    st_d.f1 = st_q.f1 + 1'b1;
                    st_d.zs = z1_inc;
                end
            end
        end

        // consumer side: byte read
        if (rd_en) begin
            if (rx_bytes == '0) begin
                st_d.rdat   = '0;
                st_d.fl.unf = 1'b1;
            end else begin
                st_d.rdat = mem_rdata;
                st_d.z2   = st_q.z2 + 1'b1;
            end
        end

        // consumer side: retire oldest frame
        if (rd_done) begin
            if (rx_frames == '0) begin
                st_d.fl.unf = 1'b1;
            end else begin
                st_d.z2 = zend;
                st_d.f2 = st_q.f2 + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdat;
    assign ovf     = st_q.fl.ovf;
    assign unf     = st_q.fl.unf;
    assign rej     = st_q.fl.rej;
    assign tx_stat = {free_frames, STAT_LO'(free_bytes)};
    assign rx_stat = {rx_frames, STAT_LO'(rx_bytes)};

endmodule

// File: rtl/hfifo_chk.sv
module hfifo_chk #(
    parameter int FW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic           wr_last,
    input logic           rd_en,
    input logic           rd_done,
    input logic [7:0]     rd_data,
    input logic [16+FW-1:0] tx_stat,
    input logic [16+FW-1:0] rx_stat,
    input logic           ovf,
    input logic           unf,
    input logic           rej
);
    // R9
    ovf_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && ((tx_stat[15:0] == 16'd0) || (tx_stat[16+FW-1:16] == '0)) |=> ovf);

    // R10
    unf_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (rx_stat[15:0] == 16'd0) |=> unf && (rd_data == 8'd0));

    // R10
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (rx_stat[15:0] == 16'd0) && !rd_done && !wr_en |=> $stable(rx_stat));

    // R8
    rej_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej |-> $past(wr_en && wr_last));

    // R3
    frames_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_last) && !rd_done |=> $stable(rx_stat[16+FW-1:16]));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && !rd_en && !rd_done |=> $stable(tx_stat));

endmodule

bind hfifo_top hfifo_chk #(.FW(FW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_last (wr_last),
    .rd_en   (rd_en),
    .rd_done (rd_done),
    .rd_data (rd_data),
    .tx_stat (tx_stat),
    .rx_stat (rx_stat),
    .ovf     (ovf),
    .unf     (unf),
    .rej     (rej)
);

// File: tb/hfifo_top_tb.sv
module hfifo_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_last = 1'b0;
    logic [7:0]  wr_data = 8'd0;
    logic        rd_en = 1'b0;
    logic        rd_done = 1'b0;
    logic [7:0]  rd_data;
    logic [19:0] tx_stat;
    logic [19:0] rx_stat;
    logic        ovf;
    logic        unf;
    logic        rej;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    hfifo_top u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_last (wr_last),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_done (rd_done),
        .rd_data (rd_data),
        .tx_stat (tx_stat),
        .rx_stat (rx_stat),
        .ovf     (ovf),
        .unf     (unf),
        .rej     (rej)
    );

    typedef struct packed {
        logic        w;
        logic        l;
        logic [7:0]  d;
        logic        r;
        logic        dn;
        logic [19:0] etx;
        logic [19:0] erx;
        logic        cd;
        logic [7:0]  ed;
        logic        eo;
        logic        eu;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 20'hF01FE, 20'h00000, 1'b0, 8'h00, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'h22, 1'b0, 1'b0, 20'hF01FD, 20'h00000, 1'b0, 8'h00, 1'b0, 1'b0},
        '{1'b1, 1'b1, 8'h33, 1'b0, 1'b0, 20'hE01FC, 20'h10003, 1'b0, 8'h00, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'h44, 1'b0, 1'b0, 20'hE01FB, 20'h10003, 1'b0, 8'h00, 1'b0, 1'b0},
        '{1'b1, 1'b1, 8'h55, 1'b0, 1'b0, 20'hD01FA, 20'h20003, 1'b0, 8'h00, 1'b0, 1'b0},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 20'hD01FB, 20'h20002, 1'b1, 8'h11, 1'b0, 1'b0},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 20'hD01FC, 20'h20001, 1'b1, 8'h22, 1'b0, 1'b0},
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 20'hE01FD, 20'h10002, 1'b0, 8'h00, 1'b0, 1'b0},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 20'hE01FE, 20'h10001, 1'b1, 8'h44, 1'b0, 1'b0},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 20'hE01FF, 20'h10000, 1'b1, 8'h55, 1'b0, 1'b0},
        '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 20'hE01FF, 20'h10000, 1'b1, 8'h00, 1'b0, 1'b1},
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 20'hF01FF, 20'h00000, 1'b0, 8'h00, 1'b0, 1'b0},
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 20'hF01FF, 20'h00000, 1'b0, 8'h00, 1'b0, 1'b1}
    };

    function automatic logic [19:0] pk(input int fr, input int by);
        return {fr[3:0], by[15:0]};
    endfunction

    task automatic chk(input string req, input logic [19:0] got, input logic [19:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic l, input logic [7:0] d,
                       input logic r, input logic dn);
        wr_en = w; wr_last = l; wr_data = d; rd_en = r; rd_done = dn;
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_last = 1'b0; rd_en = 1'b0; rd_done = 1'b0;
    endtask

    task automatic chk_reset_state(input string tag);
        chk({tag, " R1 tx"}, tx_stat, pk(15, 511));
        chk({tag, " R1 rx"}, rx_stat, 20'h0);
        chk({tag, " R1 rd_data"}, 20'(rd_data), 20'h0);
        chk({tag, " R1 flags"}, 20'({ovf, unf, rej}), 20'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk_reset_state("start");

        // table walk: R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NV; i++) begin
            cyc(VT[i].w, VT[i].l, VT[i].d, VT[i].r, VT[i].dn);
            chk($sformatf("R2 R5 tx vec %0d", i), tx_stat, VT[i].etx);
            chk($sformatf("R4 R7 rx vec %0d", i), rx_stat, VT[i].erx);
            if (VT[i].cd) chk($sformatf("R6 data vec %0d", i), 20'(rd_data), 20'(VT[i].ed));
            chk($sformatf("R9 ovf vec %0d", i), 20'(ovf), 20'(VT[i].eo));
            chk($sformatf("R10 unf vec %0d", i), 20'(unf), 20'(VT[i].eu));
        end

        // R11: wrap byte and frame pointers many times
        for (int f = 0; f < 40; f++) begin
            for (int b = 0; b < 20; b++)
                cyc(1'b1, (b == 19), 8'((f * 7 + b) & 255), 1'b0, 1'b0);
            chk($sformatf("R11 rx frame %0d", f), rx_stat, pk(1, 20));
            for (int b = 0; b < 20; b++) begin
                cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
                chk($sformatf("R11 data f%0d b%0d", f, b), 20'(rd_data), 20'((f * 7 + b) & 255));
            end
            cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
            chk($sformatf("R11 tx frame %0d", f), tx_stat, pk(15, 511));
        end

        // R9: all frame slots taken
        for (int i = 0; i < 15; i++) cyc(1'b1, 1'b1, 8'(i), 1'b0, 1'b0);
        chk("R3 slots full tx", tx_stat, pk(0, 496));
        chk("R4 slots full rx", rx_stat, pk(15, 1));
        cyc(1'b1, 1'b0, 8'hAA, 1'b0, 1'b0);
        chk("R9 ovf slots", 20'(ovf), 20'h1);
        chk("R9 tx unchanged", tx_stat, pk(0, 496));
        for (int i = 0; i < 15; i++) cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R7 drained tx", tx_stat, pk(15, 511));
        chk("R7 drained rx", rx_stat, 20'h0);

        // R8: 511-byte frame dropped
        for (int i = 0; i < 511; i++) cyc(1'b1, (i == 510), 8'(i), 1'b0, 1'b0);
        chk("R8 rej pulse", 20'(rej), 20'h1);
        chk("R8 tx released", tx_stat, pk(15, 511));
        chk("R8 rx none", rx_stat, 20'h0);
        // 510-byte frame kept
        for (int i = 0; i < 510; i++) cyc(1'b1, (i == 509), 8'(i), 1'b0, 1'b0);
        chk("R8 no rej", 20'(rej), 20'h0);
        chk("R8 rx kept", rx_stat, pk(1, 510));
        chk("R2 tx one free", tx_stat, pk(14, 1));
        // R9: all bytes taken
        cyc(1'b1, 1'b0, 8'h5A, 1'b0, 1'b0);
        chk("R2 tx byte full", tx_stat, pk(14, 0));
        cyc(1'b1, 1'b0, 8'h77, 1'b0, 1'b0);
        chk("R9 ovf bytes", 20'(ovf), 20'h1);
        chk("R9 tx still full", tx_stat, pk(14, 0));
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R7 retire unread", tx_stat, pk(15, 510));
        chk("R7 rx after skip", rx_stat, 20'h0);
        cyc(1'b1, 1'b1, 8'h6B, 1'b0, 1'b0);
        chk("R4 two-byte frame", rx_stat, pk(1, 2));
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 first byte", 20'(rd_data), 20'h5A);
        cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 second byte", 20'(rd_data), 20'h6B);

        // R1: reset mid-stream
        rst_n = 1'b0;
        #1;
        chk_reset_state("midrun");
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        chk_reset_state("after");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule